// File: doc/BRIEF.md
# Descriptor Chain Walker

This block runs the descriptor side of a memory-to-memory copy engine. Software builds a linked list of transfer descriptors in memory and programs a current pointer (the first descriptor) and a tail pointer (the last one). The walker reads each descriptor one 32-bit word at a time and checks it. It passes the source, destination and length to a separate copy engine, then writes an updated status word back into the descriptor. It continues until it has processed the tail descriptor. When wrap mode is on, it follows the next pointers without end.

Each descriptor is 32 bytes and little-endian. The fields, in memory order, are a 64-bit next pointer, a 64-bit source address, a 64-bit destination address, a 32-bit control word and a 32-bit status word. The control word holds the transfer length. The status word records completion and copy faults. If the walker finds a fault, it raises a sticky flag and stops. The flags stay set until the next run starts.

Top module: `desc_walker`

## Requirements
- R1: The current and tail pointers are 64-byte aligned. A pointer write forces bits 5:0 of the stored value to zero. The next pointer taken from a descriptor is aligned the same way.
- R2: While `sg_mode` is low and the walker is idle, pointer writes are ignored and both `cur_ptr` and `tail_ptr` read as zero.
- R3: A run starts on an accepted write to the tail pointer. With `ADDR_W` = 32, the low-word write starts it and high-word writes are ignored. With `ADDR_W` > 32, only the high-word write starts it, and a low-word write only updates the stored value. Starting a run clears all three error flags.
- R4: The walker fetches the eight words of a descriptor at byte offsets 0,4,...,28 from the current pointer. Words 0/1 form the next pointer, 2/3 the source and 4/5 the destination, each with the low word first. Word 6 is control, and its bits 25:0 are the length. Word 7 is status. The walker then issues one copy command carrying that source, destination and length.
- R5: If bit 31 of the fetched status word is already set, the walker sets `err_sg_int` and stops. It issues no copy command and no write-back.
- R6: If the length field is zero, the walker sets `err_sg_int` and stops without issuing a copy command.
- R7: A memory error on a descriptor read or on the status write-back sets `err_sg_dec` and stops the walker with no completion pulse.
- R8: If the copy engine reports failure, the walker sets `err_dma_dec`, sets bit 30 of the status word, writes the status word back and stops with no completion pulse.
- R9: On a successful copy, the walker sets bit 31 of the status word and writes only that word back, at byte offset 28. It then emits exactly one single-cycle `desc_done` pulse.
- R10: After each completed descriptor, the current pointer takes the next-pointer value. The run ends if the descriptor just completed was the tail and `cyclic` is low. If `cyclic` is high, the walker keeps following next pointers.
- R11: Pointer writes made while `busy` is high are dropped and cannot start a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sg_mode | input | 1 | Descriptor mode enable |
| cyclic | input | 1 | Keep walking past the tail |
| ptr_wr_en | input | 1 | Pointer register write strobe |
| ptr_wr_tail | input | 1 | 1 selects the tail pointer, 0 the current pointer |
| ptr_wr_hi | input | 1 | 1 writes bits 63:32, 0 writes bits 31:0 |
| ptr_wr_data | input | 32 | Pointer write data |
| cur_ptr | output | 64 | Current descriptor pointer |
| tail_ptr | output | 64 | Tail descriptor pointer |
| busy | output | 1 | Walker is running |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 for status write-back, 0 for fetch |
| mem_addr | output | 64 | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write-back status word |
| mem_ack | input | 1 | Memory response strobe |
| mem_err | input | 1 | Response carries an error (valid with `mem_ack`) |
| mem_rdata | input | 32 | Read data (valid with `mem_ack`) |
| cp_valid | output | 1 | Copy command pending, held until `cp_done` |
| cp_src | output | 64 | Copy source address |
| cp_dst | output | 64 | Copy destination address |
| cp_len | output | 26 | Copy length in bytes |
| cp_done | input | 1 | Copy finished |
| cp_fail | input | 1 | Copy failed (valid with `cp_done`) |
| desc_done | output | 1 | One pulse per completed descriptor |
| err_sg_int | output | 1 | Sticky: descriptor rejected |
| err_sg_dec | output | 1 | Sticky: descriptor memory access failed |
| err_dma_dec | output | 1 | Sticky: copy failed |

## Verification
Some internal faults show up only through the copy commands. A wrong word index or byte order during fetch shows in the first command after the eighth fetched word. A bad pointer advance shows in the command for the following descriptor, or in `cur_ptr` once the walker goes idle. A faulty tail comparison or wrap decision shows as too many or too few copy commands and completion pulses by the end of a run. A wrong status update is visible in memory right after the write-back acknowledge. The scoreboard therefore checks every copy command against an ordered list of expected commands, and the final pointer, pulse count, flags and memory are checked once `busy` falls.

// File: rtl/desc_walker.sv
module desc_walker #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sg_mode,
  input  logic              cyclic,
  input  logic              ptr_wr_en,
  input  logic              ptr_wr_tail,
  input  logic              ptr_wr_hi,
  input  logic [31:0]       ptr_wr_data,
  output logic [63:0]       cur_ptr,
  output logic [63:0]       tail_ptr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [63:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic              cp_valid,
  output logic [63:0]       cp_src,
  output logic [63:0]       cp_dst,
  output logic [LEN_W-1:0]  cp_len,
  input  logic              cp_done,
  input  logic              cp_fail,
  output logic              desc_done,
  output logic              err_sg_int,
  output logic              err_sg_dec,
  output logic              err_dma_dec
);
  localparam bit WIDE = (ADDR_W > 32);
  localparam logic [63:0] STAT_OFS = 64'd28;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_COPY, S_WB} st_t;

  st_t         st;
  logic [2:0]  widx;
  logic [31:0] dw [8];
  logic [63:0] cur_q, tail_q;
  logic        cp_bad;

  wire wr_accept = ptr_wr_en && sg_mode && (st == S_IDLE) && (!ptr_wr_hi || WIDE);
  wire start     = wr_accept && ptr_wr_tail && (ptr_wr_hi == WIDE);
  wire [63:0] wr_val_cur  = ptr_wr_hi ? {ptr_wr_data, cur_q[31:0]}
                                      : {cur_q[63:32], ptr_wr_data[31:6], 6'b0};
  wire [63:0] wr_val_tail = ptr_wr_hi ? {ptr_wr_data, tail_q[31:0]}
                                      : {tail_q[63:32], ptr_wr_data[31:6], 6'b0};
  wire [63:0] next_ptr = {dw[1], dw[0][31:6], 6'b0};
  wire        len_zero = (dw[6][LEN_W-1:0] == '0);

  assign busy      = (st != S_IDLE);
  assign cur_ptr   = cur_q;
  assign tail_ptr  = tail_q;
  assign mem_req   = (st == S_FETCH) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = cur_q + ((st == S_WB) ? STAT_OFS : {59'd0, widx, 2'b00});
  assign mem_wdata = dw[7];
  assign cp_valid  = (st == S_COPY);
  assign cp_src    = {dw[3], dw[2]};
  assign cp_dst    = {dw[5], dw[4]};
  assign cp_len    = dw[6][LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      widx        <= '0;
      cur_q       <= '0;
      tail_q      <= '0;
      cp_bad      <= 1'b0;
      desc_done   <= 1'b0;
      err_sg_int  <= 1'b0;
      err_sg_dec  <= 1'b0;
      err_dma_dec <= 1'b0;
      for (int i = 0; i < 8; i++) dw[i] <= '0;
    end else begin
      desc_done <= 1'b0;
      if (!sg_mode && st == S_IDLE) begin
        cur_q  <= '0;
        tail_q <= '0;
      end else if (wr_accept) begin
        if (ptr_wr_tail) tail_q <= wr_val_tail;
        else             cur_q  <= wr_val_cur;
      end
      case (st)
        S_IDLE: if (start) begin
          st          <= S_FETCH;
          widx        <= '0;
          err_sg_int  <= 1'b0;
          err_sg_dec  <= 1'b0;
          err_dma_dec <= 1'b0;
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin
            err_sg_dec <= 1'b1;
            st         <= S_IDLE;
          end else begin
            dw[widx] <= mem_rdata;
            widx     <= widx + 3'd1;
            if (widx == 3'd7) st <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (dw[7][31] || len_zero) begin
            err_sg_int <= 1'b1;
            st         <= S_IDLE;
          end else begin
            st <= S_COPY;
          end
        end
        S_COPY: if (cp_done) begin
          cp_bad <= cp_fail;
          if (cp_fail) begin
            err_dma_dec <= 1'b1;
            dw[7][30]   <= 1'b1;
          end else begin
            dw[7][31] <= 1'b1;
          end
          st <= S_WB;
        end
        S_WB: if (mem_ack) begin
          if (mem_err) begin
            err_sg_dec <= 1'b1;
            st         <= S_IDLE;
          end else if (cp_bad) begin
            st <= S_IDLE;
          end else begin
            desc_done <= 1'b1;
            cur_q     <= next_ptr;
            widx      <= '0;
            st        <= (!cyclic && cur_q == tail_q) ? S_IDLE : S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module desc_walker_chk #(
  parameter int LEN_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sg_mode,
  input logic             ptr_wr_en,
  input logic [63:0]      cur_ptr,
  input logic [63:0]      tail_ptr,
  input logic             busy,
  input logic             mem_we,
  input logic [63:0]      mem_addr,
  input logic             cp_valid,
  input logic [LEN_W-1:0] cp_len,
  input logic             desc_done,
  input logic             err_sg_int,
  input logic             err_sg_dec,
  input logic             err_dma_dec
);
  // R1
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ptr[5:0] == 6'd0) && (tail_ptr[5:0] == 6'd0));
  // R2
  mode_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sg_mode && !busy) |=> (cur_ptr == 64'd0) && (tail_ptr == 64'd0));
  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ptr_wr_en) |=> $stable(tail_ptr));
  // R4
  copy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid |-> (cp_len != '0));
  // R5
  int_err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sg_int) |-> !busy);
  // R7
  dec_err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sg_dec) |-> !busy && !desc_done);
  // R8
  copy_err_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_dma_dec) |-> !desc_done);
  // R9
  wb_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[4:0] == 5'h1C));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done);
endmodule

bind desc_walker desc_walker_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/desc_walker_tb.sv
module desc_walker_tb;
  localparam int CLK_P = 10;
  localparam logic [63:0] FAIL_SRC = 64'h0000_0000_DEAD_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        sg_mode = 1'b0, cyclic = 1'b0;
  logic        ptr_wr_en = 1'b0, ptr_wr_tail = 1'b0, ptr_wr_hi = 1'b0;
  logic [31:0] ptr_wr_data = '0;
  logic [63:0] cur_ptr, tail_ptr, mem_addr, cp_src, cp_dst;
  logic        busy, mem_req, mem_we, cp_valid, desc_done;
  logic        err_sg_int, err_sg_dec, err_dma_dec;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        cp_done = 1'b0, cp_fail = 1'b0;
  logic [25:0] cp_len;

  desc_walker u_dut (
    .clk(clk), .rst_n(rst_n), .sg_mode(sg_mode), .cyclic(cyclic),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_tail(ptr_wr_tail), .ptr_wr_hi(ptr_wr_hi),
    .ptr_wr_data(ptr_wr_data), .cur_ptr(cur_ptr), .tail_ptr(tail_ptr), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .cp_valid(cp_valid), .cp_src(cp_src), .cp_dst(cp_dst), .cp_len(cp_len),
    .cp_done(cp_done), .cp_fail(cp_fail), .desc_done(desc_done),
    .err_sg_int(err_sg_int), .err_sg_dec(err_sg_dec), .err_dma_dec(err_dma_dec));

  // 32-bit addressing variant: only its start behaviour is observed
  logic        n_en = 1'b0, n_hi = 1'b0;
  logic [31:0] n_data = '0;
  logic [63:0] n_cur, n_tail, n_maddr, n_src, n_dst;
  logic        n_busy, n_req, n_we, n_cpv, n_done, n_ei, n_ed, n_edd;
  logic [31:0] n_wdata;
  logic [25:0] n_len;

  desc_walker #(.ADDR_W(32)) u_dut32 (
    .clk(clk), .rst_n(rst_n), .sg_mode(1'b1), .cyclic(1'b0),
    .ptr_wr_en(n_en), .ptr_wr_tail(1'b1), .ptr_wr_hi(n_hi), .ptr_wr_data(n_data),
    .cur_ptr(n_cur), .tail_ptr(n_tail), .busy(n_busy),
    .mem_req(n_req), .mem_we(n_we), .mem_addr(n_maddr), .mem_wdata(n_wdata),
    .mem_ack(1'b0), .mem_err(1'b0), .mem_rdata(32'd0),
    .cp_valid(n_cpv), .cp_src(n_src), .cp_dst(n_dst), .cp_len(n_len),
    .cp_done(1'b0), .cp_fail(1'b0), .desc_done(n_done),
    .err_sg_int(n_ei), .err_sg_dec(n_ed), .err_dma_dec(n_edd));

  int checks = 0, errors = 0, done_cnt = 0, copy_cnt = 0;
  logic [31:0] mem [0:255];
  logic        wb_err_en = 1'b0;
  logic [153:0] exp_q [$];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one ack per request, data read at address/4
  initial forever begin
    @(negedge clk);
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      mem_ack = 1'b1;
      mem_err = (mem_addr >= 64'h400) || (mem_we && wb_err_en);
      if (!mem_err) begin
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[9:2]];
      end
    end
  end

  // copy engine model + scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (cp_done) begin
      cp_done = 1'b0;
      cp_fail = 1'b0;
    end else if (cp_valid) begin
      copy_cnt++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected copy actual=%h expected=none", {cp_src, cp_dst, cp_len});
      end else begin
        logic [153:0] e;
        e = exp_q.pop_front();
        if ({cp_src, cp_dst, cp_len} !== e) begin
          errors++;
          $display("FAIL R4 copy command actual=%h expected=%h", {cp_src, cp_dst, cp_len}, e);
        end
      end
      cp_fail = (cp_src == FAIL_SRC);
      cp_done = 1'b1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (desc_done) done_cnt++;
  end

  task automatic put_desc(int a, logic [63:0] nxt, logic [63:0] src, logic [63:0] dst,
                          logic [31:0] ctl, logic [31:0] stat, bit expect_copy);
    mem[a/4+0] = nxt[31:0]; mem[a/4+1] = nxt[63:32];
    mem[a/4+2] = src[31:0]; mem[a/4+3] = src[63:32];
    mem[a/4+4] = dst[31:0]; mem[a/4+5] = dst[63:32];
    mem[a/4+6] = ctl;       mem[a/4+7] = stat;
    if (expect_copy) exp_q.push_back({src, dst, ctl[25:0]});
  endtask

  task automatic wr_ptr(bit tail, bit hi, logic [31:0] d);
    @(negedge clk);
    ptr_wr_en = 1'b1; ptr_wr_tail = tail; ptr_wr_hi = hi; ptr_wr_data = d;
    @(negedge clk);
    ptr_wr_en = 1'b0;
  endtask

  task automatic run(logic [31:0] cur, logic [31:0] tail);
    wr_ptr(1'b0, 1'b0, cur);
    wr_ptr(1'b0, 1'b1, 32'd0);
    wr_ptr(1'b1, 1'b0, tail);
    wr_ptr(1'b1, 1'b1, 32'd0);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0, c0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset cur", cur_ptr, 0);
    check("reset tail", tail_ptr, 0);
    check("reset busy", {63'd0, busy}, 0);
    check("reset flags", {61'd0, err_sg_int, err_sg_dec, err_dma_dec}, 0);

    // R2: mode off ignores writes
    wr_ptr(1'b0, 1'b0, 32'h140);
    wr_ptr(1'b1, 1'b1, 32'h5);
    check("R2 cur", cur_ptr, 0);
    check("R2 tail", tail_ptr, 0);

    // R1: alignment
    sg_mode = 1'b1;
    wr_ptr(1'b0, 1'b0, 32'h7F);
    check("R1 cur masked", cur_ptr, 64'h40);

    // R3 R4 R9 R10 R11: three-descriptor chain
    put_desc(32'h000, 64'h040, 64'h1_0000_1000, 64'h2000, 32'h10, 0, 1);
    put_desc(32'h040, 64'h080, 64'h1100, 64'h3_0000_2100, 32'h24, 0, 1);
    put_desc(32'h080, 64'h0C0, 64'h1200, 64'h2200, 32'h3FF_FFFF, 0, 1);
    d0 = done_cnt;
    wr_ptr(1'b0, 1'b0, 32'h000);
    wr_ptr(1'b0, 1'b1, 32'h0);
    wr_ptr(1'b1, 1'b0, 32'h080);
    check("R3 low tail write no start", {63'd0, busy}, 0);
    wr_ptr(1'b1, 1'b1, 32'h0);
    check("R3 high tail write starts", {63'd0, busy}, 1);
    wr_ptr(1'b0, 1'b0, 32'h300);
    wr_ptr(1'b1, 1'b0, 32'h300);
    wr_ptr(1'b1, 1'b1, 32'h0);
    wait_idle();
    check("R9 done pulses", done_cnt - d0, 3);
    check("R4 all copies issued", exp_q.size(), 0);
    check("R9 status A", mem[7], 32'h8000_0000);
    check("R9 status C", mem[32+7], 32'h8000_0000);
    check("R9 ctl untouched", mem[32+6], 32'h3FF_FFFF);
    check("R10 cur after tail", cur_ptr, 64'h0C0);
    check("R11 tail kept", tail_ptr, 64'h080);
    check("R9 no flags", {61'd0, err_sg_int, err_sg_dec, err_dma_dec}, 0);

    // R5: already completed
    put_desc(32'h100, 64'h140, 64'h1000, 64'h2000, 32'h8, 32'h8000_0000, 0);
    c0 = copy_cnt; d0 = done_cnt;
    run(32'h100, 32'h100);
    wait_idle();
    check("R5 sg int flag", {63'd0, err_sg_int}, 1);
    check("R5 no copy", copy_cnt - c0, 0);
    check("R5 no done", done_cnt - d0, 0);

    // R6: zero length
    put_desc(32'h140, 64'h180, 64'h1000, 64'h2000, 32'hFC00_0000, 0, 0);
    c0 = copy_cnt;
    run(32'h140, 32'h140);
    wait_idle();
    check("R6 sg int flag", {63'd0, err_sg_int}, 1);
    check("R6 no copy", copy_cnt - c0, 0);
    check("R6 status untouched", mem[80+7], 0);

    // R7: fetch failure
    c0 = copy_cnt;
    run(32'h400, 32'h400);
    wait_idle();
    check("R7 fetch dec flag", {63'd0, err_sg_dec}, 1);
    check("R7 int flag cleared on start", {63'd0, err_sg_int}, 0);
    check("R7 no copy", copy_cnt - c0, 0);

    // R8: copy failure
    put_desc(32'h180, 64'h1C0, FAIL_SRC, 64'h2000, 32'h20, 0, 1);
    d0 = done_cnt;
    run(32'h180, 32'h1C0);
    wait_idle();
    check("R8 dma dec flag", {63'd0, err_dma_dec}, 1);
    check("R8 status bit30", mem[96+7], 32'h4000_0000);
    check("R8 no done", done_cnt - d0, 0);
    check("R8 halted cur", cur_ptr, 64'h180);

    // R7: write-back failure
    put_desc(32'h1C0, 64'h200, 64'h1000, 64'h2000, 32'h4, 0, 1);
    d0 = done_cnt;
    wb_err_en = 1'b1;
    run(32'h1C0, 32'h1C0);
    wait_idle();
    wb_err_en = 1'b0;
    check("R7 wb dec flag", {63'd0, err_sg_dec}, 1);
    check("R7 wb no done", done_cnt - d0, 0);
    check("R7 wb memory unchanged", mem[112+7], 0);

    // R10: cyclic wraps past tail until it meets a completed descriptor
    put_desc(32'h200, 64'h240, 64'h5000, 64'h6000, 32'h40, 0, 1);
    put_desc(32'h240, 64'h200, 64'h5100, 64'h6100, 32'h44, 0, 1);
    cyclic = 1'b1;
    d0 = done_cnt;
    run(32'h200, 32'h200);
    wait_idle();
    check("R10 cyclic done count", done_cnt - d0, 2);
    check("R10 cyclic wrapped cur", cur_ptr, 64'h200);
    check("R10 cyclic stops on completed", {63'd0, err_sg_int}, 1);
    check("R10 cyclic copies", exp_q.size(), 0);

    // R10: same chain without cyclic stops at tail
    cyclic = 1'b0;
    put_desc(32'h200, 64'h240, 64'h5000, 64'h6000, 32'h40, 0, 1);
    put_desc(32'h240, 64'h200, 64'h5100, 64'h6100, 32'h44, 0, 0);
    d0 = done_cnt;
    run(32'h200, 32'h200);
    wait_idle();
    check("R10 tail stop done", done_cnt - d0, 1);
    check("R10 tail stop cur", cur_ptr, 64'h240);
    check("R10 tail stop no flag", {63'd0, err_sg_int}, 0);
    check("R10 second untouched", mem[144+7], 0);

    // R3: 32-bit addressing starts on the low word, ignores high word
    @(negedge clk); n_en = 1'b1; n_hi = 1'b1; n_data = 32'h7;
    @(negedge clk); n_en = 1'b0;
    check("R3 32b high ignored", n_tail, 0);
    check("R3 32b high no start", {63'd0, n_busy}, 0);
    @(negedge clk); n_en = 1'b1; n_hi = 1'b0; n_data = 32'h1C5;
    @(negedge clk); n_en = 1'b0;
    check("R3 32b low starts", {63'd0, n_busy}, 1);
    check("R3 32b tail masked", n_tail, 64'h1C0);

    // R2: leaving descriptor mode clears the pointers
    sg_mode = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 cleared cur", cur_ptr, 0);
    check("R2 cleared tail", tail_ptr, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule